// File: doc/BRIEF.md
# Cache-Line Lock Snoop Retry Unit

This unit enforces exclusive-access sequences for a target that sits between a PCI-style bus and a host processor bus. A locked access from the PCI side becomes a lock when its completion is reported. At that point the unit records the master that made the access. It also records the base of the 32-byte cache line that contains the access address.

While a lock is held, the unit handles the two buses differently. On the host side, every snooped transaction is compared with the locked line. A hit gets a standalone retry in the same cycle. On the PCI side, the whole target is closed to every master except the owner, whatever address that master uses.

The owner ends the sequence by presenting an unlock. The lock then stays in force until the owner's next successful completion. It drops on the clock edge that follows that completion.

Top module: `cl_lock_snoop_retry`

## Requirements
- R1: Reset clears the lock. After reset, neither `snp_retry` nor `pci_req_retry` is asserted until a new lock is set up.
- R2: A lock is set up only by a completion with `cpl_vld=1` and `cpl_locked=1` while no lock is held. It captures `cpl_mid` as owner and `cpl_addr` with bits [4:0] cleared as the line base. For example, 0x1000_0028 locks 0x1000_0020 through 0x1000_003F. The lock is visible from the cycle after that completion.
- R3: While a lock is held, a snoop with `snp_vld=1` whose address bits [31:5] equal those of the line base raises `snp_retry` combinationally in the same cycle.
- R4: `snp_retry` stays low for snoop addresses outside the locked line, when no lock is held, and whenever `snp_vld=0`.
- R5: While a lock is held, a request with `pci_req_vld=1` from any master ID other than the owner raises `pci_req_retry` in the same cycle. Requests from the owner are never retried. With no lock held, no request is retried.
- R6: A completion with `cpl_locked=0` sets up no lock. While a lock is held, completions from non-owners, including locked ones, change neither the owner nor the line.
- R7: An unlock (`unl_vld=1`) from a master other than the owner is ignored. An unlock from the owner alone does not release the lock.
- R8: After the owner has presented an unlock, the owner's next completion releases the lock on the following edge. A snoop to the line in the same cycle as that completion is still retried. From the next cycle on, no retry is given.
- R9: Owner completions before any unlock leave the lock and its line unchanged.
- R10: An owner completion in the same cycle as the owner's unlock does not count as the final one. A later owner completion is needed for release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pci_req_vld | input | 1 | PCI-side access request present |
| pci_req_mid | input | 4 | Master ID of the requester |
| pci_req_retry | output | 1 | Retry the current PCI request (target locked by another master) |
| cpl_vld | input | 1 | A PCI access completed successfully this cycle |
| cpl_mid | input | 4 | Master ID of the completed access |
| cpl_addr | input | 32 | Address of the completed access |
| cpl_locked | input | 1 | The completed access was flagged as locked |
| unl_vld | input | 1 | Unlock presented this cycle |
| unl_mid | input | 4 | Master ID presenting the unlock |
| snp_vld | input | 1 | Host-bus transaction being snooped |
| snp_addr | input | 32 | Host-bus transaction address |
| snp_retry | output | 1 | Retry the snooped host transaction |

## Verification
On every cycle, the assertions check the following:
- Both retry outputs appear only with their own valid inputs and only while a lock is held.
- A lock begins only after a locked completion.
- The owner and line stay fixed for as long as the lock lasts.
- A release follows an owner completion.

Only the bench scenarios can show the rest:
- the exact line boundaries;
- that non-owner unlocks and completions are ignored;
- the same-cycle unlock-plus-completion case;
- that a snoop in the final completion cycle is still retried.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    parameter int unsigned LSR_ADDR_W     = 32;
    parameter int unsigned LSR_LINE_BYTES = 32;
    parameter int unsigned LSR_MID_W      = 4;

    // Mask that keeps the line-base bits of an address.
    function automatic logic [LSR_ADDR_W-1:0] line_mask(input int unsigned line_bytes);
        line_mask = ~(LSR_ADDR_W'(line_bytes - 1));
    endfunction
endpackage

// File: rtl/lsr_lock_state.sv
module lsr_lock_state
    import lsr_pkg::*;
#(
    parameter int unsigned ADDR_W     = LSR_ADDR_W,
    parameter int unsigned LINE_BYTES = LSR_LINE_BYTES,
    parameter int unsigned MID_W      = LSR_MID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpl_vld,
    input  logic [MID_W-1:0]  cpl_mid,
    input  logic [ADDR_W-1:0] cpl_addr,
    input  logic              cpl_locked,
    input  logic              unl_vld,
    input  logic [MID_W-1:0]  unl_mid,
    output logic              held,
    output logic [MID_W-1:0]  owner,
    output logic [ADDR_W-1:0] base
);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'(LINE_BYTES - 1));

    typedef struct packed {
        logic              held;
        logic              pend;
        logic [MID_W-1:0]  owner;
        logic [ADDR_W-1:0] base;
    } lock_st_t;

    lock_st_t st_d, st_q;
    logic     own_cpl;
    logic     own_unl;

    always_comb begin
        st_d    = st_q;
        own_cpl = cpl_vld && (cpl_mid == st_q.owner);
        own_unl = unl_vld && (unl_mid == st_q.owner);
        if (!st_q.held) begin
            if (cpl_vld && cpl_locked) begin
                st_d.held  = 1'b1;
                st_d.pend  = 1'b0;
                st_d.owner = cpl_mid;
                st_d.base  = cpl_addr & LINE_MASK;
            end
        end else if (st_q.pend && own_cpl) begin
            st_d.held = 1'b0;
            st_d.pend = 1'b0;
        end else if (own_unl) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held  = st_q.held;
    assign owner = st_q.owner;
    assign base  = st_q.base;
endmodule

// File: rtl/lsr_line_match.sv
module lsr_line_match
    import lsr_pkg::*;
#(
    parameter int unsigned ADDR_W     = LSR_ADDR_W,
    parameter int unsigned LINE_BYTES = LSR_LINE_BYTES
) (
    input  logic              snp_vld,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              held,
    input  logic [ADDR_W-1:0] base,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'(LINE_BYTES - 1));

    always_comb begin
        hit = snp_vld && held && ((snp_addr & LINE_MASK) == base);
    end
endmodule

// File: rtl/lsr_owner_gate.sv
module lsr_owner_gate
    import lsr_pkg::*;
#(
    parameter int unsigned MID_W = LSR_MID_W
) (
    input  logic             req_vld,
    input  logic [MID_W-1:0] req_mid,
    input  logic             held,
    input  logic [MID_W-1:0] owner,
    output logic             retry
);
    always_comb begin
        retry = req_vld && held && (req_mid != owner);
    end
endmodule

// File: rtl/cl_lock_snoop_retry.sv
module cl_lock_snoop_retry
    import lsr_pkg::*;
#(
    parameter int unsigned ADDR_W     = LSR_ADDR_W,
    parameter int unsigned LINE_BYTES = LSR_LINE_BYTES,
    parameter int unsigned MID_W      = LSR_MID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pci_req_vld,
    input  logic [MID_W-1:0]  pci_req_mid,
    output logic              pci_req_retry,
    input  logic              cpl_vld,
    input  logic [MID_W-1:0]  cpl_mid,
    input  logic [ADDR_W-1:0] cpl_addr,
    input  logic              cpl_locked,
    input  logic              unl_vld,
    input  logic [MID_W-1:0]  unl_mid,
    input  logic              snp_vld,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_retry
);
    logic              held_w;
    logic [MID_W-1:0]  owner_w;
    logic [ADDR_W-1:0] base_w;

    lsr_lock_state #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MID_W(MID_W)
    ) u_state (
        .clk(clk), .rst_n(rst_n),
        .cpl_vld(cpl_vld), .cpl_mid(cpl_mid), .cpl_addr(cpl_addr), .cpl_locked(cpl_locked),
        .unl_vld(unl_vld), .unl_mid(unl_mid),
        .held(held_w), .owner(owner_w), .base(base_w)
    );

    lsr_line_match #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
    ) u_match (
        .snp_vld(snp_vld), .snp_addr(snp_addr),
        .held(held_w), .base(base_w), .hit(snp_retry)
    );

    lsr_owner_gate #(
        .MID_W(MID_W)
    ) u_gate (
        .req_vld(pci_req_vld), .req_mid(pci_req_mid),
        .held(held_w), .owner(owner_w), .retry(pci_req_retry)
    );
endmodule

// File: rtl/lsr_checker.sv
module lsr_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned MID_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              snp_vld,
    input logic              snp_retry,
    input logic              pci_req_vld,
    input logic              pci_req_retry,
    input logic              cpl_vld,
    input logic              cpl_locked,
    input logic [MID_W-1:0]  cpl_mid,
    input logic              held_w,
    input logic [MID_W-1:0]  owner_w,
    input logic [ADDR_W-1:0] base_w
);
    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !held_w);

    assert_lock_needs_locked_cpl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held_w) |-> $past(cpl_vld && cpl_locked));

    assert_snoop_retry_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
        snp_retry |-> (snp_vld && held_w));

    assert_pci_retry_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req_retry |-> (pci_req_vld && held_w));

    assert_lock_fields_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (held_w && $past(held_w)) |-> ($stable(owner_w) && $stable(base_w)));

    assert_release_on_owner_cpl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(held_w) |-> $past(cpl_vld && (cpl_mid == owner_w)));
endmodule

bind cl_lock_snoop_retry lsr_checker #(.ADDR_W(ADDR_W), .MID_W(MID_W)) u_chk (.*);

// File: tb/cl_lock_snoop_retry_bench.sv
module cl_lock_snoop_retry_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pci_req_vld = 1'b0;
    logic [3:0]  pci_req_mid = '0;
    logic        pci_req_retry;
    logic        cpl_vld = 1'b0;
    logic [3:0]  cpl_mid = '0;
    logic [31:0] cpl_addr = '0;
    logic        cpl_locked = 1'b0;
    logic        unl_vld = 1'b0;
    logic [3:0]  unl_mid = '0;
    logic        snp_vld = 1'b0;
    logic [31:0] snp_addr = '0;
    logic        snp_retry;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp_snp;
        logic  exp_pci;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    cl_lock_snoop_retry u_cl_lock_snoop_retry (.*);

    task automatic drive(
        input logic s_v, input logic [31:0] s_a,
        input logic r_v, input logic [3:0] r_m,
        input logic c_v, input logic [3:0] c_m, input logic [31:0] c_a, input logic c_l,
        input logic u_v, input logic [3:0] u_m,
        input logic e_s, input logic e_p, input string tag);
        exp_t it;
        @(negedge clk);
        snp_vld = s_v; snp_addr = s_a;
        pci_req_vld = r_v; pci_req_mid = r_m;
        cpl_vld = c_v; cpl_mid = c_m; cpl_addr = c_a; cpl_locked = c_l;
        unl_vld = u_v; unl_mid = u_m;
        it.exp_snp = e_s; it.exp_pci = e_p; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: sample 4 ns after the driving edge, before the next rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (sb_q.size() != 0) begin
                exp_t it;
                it = sb_q.pop_front();
                checks++;
                if (snp_retry !== it.exp_snp) begin
                    failures++;
                    $display("FAIL %s snp_retry actual=%b expected=%b", it.tag, snp_retry, it.exp_snp);
                end
                checks++;
                if (pci_req_retry !== it.exp_pci) begin
                    failures++;
                    $display("FAIL %s pci_req_retry actual=%b expected=%b", it.tag, pci_req_retry, it.exp_pci);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: fresh state
        drive(1, 32'h1000_0020, 1, 4'd5, 0, 0, 0, 0, 0, 0, 0, 0, "R1 post-reset");
        // R6: unlocked completion makes no lock
        drive(1, 32'h1000_0020, 1, 4'd5, 1, 4'd3, 32'h1000_0028, 0, 0, 0, 0, 0, "R6 unlocked cpl");
        drive(1, 32'h1000_0020, 1, 4'd5, 1, 4'd3, 32'h1000_0028, 1, 0, 0, 0, 0, "R6 no lock yet / R2 lock cpl");
        // R2/R3/R5: lock on 0x1000_0020 owned by master 3
        drive(1, 32'h1000_0020, 1, 4'd5, 0, 0, 0, 0, 0, 0, 1, 1, "R2 R3 R5 base hit, non-owner");
        drive(1, 32'h1000_003F, 1, 4'd3, 0, 0, 0, 0, 0, 0, 1, 0, "R2 R3 R5 top of line, owner");
        drive(1, 32'h1000_001F, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 below line");
        drive(1, 32'h1000_0040, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 above line");
        drive(0, 32'h1000_0028, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 snoop not valid");
        // R6/R7: non-owner locked completion and non-owner unlock
        drive(1, 32'h1000_0020, 1, 4'd9, 1, 4'd5, 32'h2000_0000, 1, 1, 4'd5, 1, 1, "R6 R7 non-owner activity");
        drive(1, 32'h2000_0000, 0, 0, 1, 4'd3, 32'h1000_0028, 1, 0, 0, 0, 0, "R6 line not replaced");
        // R7/R9: owner completion without a valid unlock keeps the lock
        drive(1, 32'h1000_0024, 1, 4'd5, 0, 0, 0, 0, 0, 0, 1, 1, "R7 R9 lock kept");
        // R10: unlock and completion in the same cycle
        drive(1, 32'h1000_0020, 0, 0, 1, 4'd3, 32'h1000_0028, 1, 1, 4'd3, 1, 0, "R10 unlock+cpl");
        drive(1, 32'h1000_0020, 1, 4'd5, 0, 0, 0, 0, 0, 0, 1, 1, "R10 still held");
        // R8: final completion, snoop same cycle still retried
        drive(1, 32'h1000_0030, 1, 4'd5, 1, 4'd3, 32'h1000_0028, 1, 0, 0, 1, 1, "R8 final cpl cycle");
        drive(1, 32'h1000_0020, 1, 4'd5, 0, 0, 0, 0, 0, 0, 0, 0, "R8 released");
        // R2: new lock by master 5 at 0x5
        drive(1, 32'h0000_0000, 1, 4'd3, 1, 4'd5, 32'h0000_0005, 1, 0, 0, 0, 0, "R2 relock cpl");
        drive(1, 32'h0000_001C, 1, 4'd3, 0, 0, 0, 0, 0, 0, 1, 1, "R2 R5 relocked line");
        drive(1, 32'h0000_0020, 1, 4'd5, 0, 0, 0, 0, 0, 0, 0, 0, "R4 R5 next line, owner");
        // R1: reset while locked
        @(negedge clk) begin
            rst_n = 1'b0;
            snp_vld = 0; pci_req_vld = 0; cpl_vld = 0; unl_vld = 0;
        end
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive(1, 32'h0000_0000, 1, 4'd3, 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset drops lock");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule